// File: doc/BRIEF.md
# Multiplexed Interrupt Request Concentrator

This block carries up to thirty-two interrupt sources over eight shared request lines. It takes turns between groups of eight sources, one group per clock. A slot indicator travels next to the lines and names the group that is on the lines in that cycle. On the receiving side, each group's lines are latched into the matching bits of a 32-bit pending register. Software reads that register through a simple access port, and only a supervisor access returns its contents.

A two-bit mode input sets how many groups share the lines:

| Mode | Groups | Sources carried |
|------|--------|-----------------|
| 0 | 1 | 0–7 |
| 1 | 2 | 0–15 |
| 2 | 3 | 0–23 |
| 3 | 4 | 0–31 |

Mode 2 uses three groups, so the slot sequence runs 0, 1, 2 and then wraps. When the mode changes, the slot sequence restarts and any pending bits outside the new range are dropped.

Top module: `irq_mux_concentrator`

## Requirements
- R1: While reset is held, the pending register reads as zero and the slot output is 0.
- R2: The slot output advances by one each clock and wraps to 0 after slot number equal to the active mode. Mode m runs slots 0..m.
- R3: In every cycle, line j carries source 8*slot+j.
- R4: At each clock edge that is not a mode change, pending bits 8*slot..8*slot+7 take the values on the lines. All other pending bits keep their value.
- R5: With sources held steady long enough, pending bit n equals source n for every n inside the mode's range. The range is 0–7 for mode 0, 0–15 for mode 1, 0–23 for mode 2 and 0–31 for mode 3. Every bit outside the range reads 0.
- R6: At the first edge where the mode input differs from the active mode:
  - the new mode becomes active;
  - the slot returns to 0;
  - pending bits outside the new range are cleared;
  - no capture takes place at that edge.
- R7: An access with acc_en=1, acc_wr=0 and acc_super=1 returns the pending register on rd_data in the same cycle. Bit n of rd_data holds source n.
- R8: Any access with acc_super=0 returns rd_data=0 and raises rd_err in the same cycle. rd_err is 0 otherwise.
- R9: A write access (acc_wr=1) returns rd_data=0 and leaves the pending register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Multiplexing ratio select (groups minus one) |
| src | input | 32 | Interrupt source levels, source n on bit n |
| line | output | 8 | Shared request lines |
| slot | output | 2 | Group currently on the lines |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | Access is a write |
| acc_super | input | 1 | Access is made in supervisor mode |
| rd_data | output | 32 | Pending register read data |
| rd_err | output | 1 | Access error for a non-supervisor access |

## Verification
The assertions assume two things about the inputs:
- The mode input only changes in ways that a registered copy can follow, so every change is seen at one edge.
- The sources are plain levels that are sampled on the same clock.

The stimulus changes mode, sources and access signals only on falling edges. After every mode or source change it waits several full slot rounds before it judges pending contents. The one exception is the hold and change scenarios, which check the exact edge on purpose.

// File: rtl/irq_mux_concentrator.sv
module irq_mux_concentrator #(
  parameter int NLINES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            mode,
  input  logic [4*NLINES-1:0]   src,
  output logic [NLINES-1:0]     line,
  output logic [1:0]            slot,
  input  logic                  acc_en,
  input  logic                  acc_wr,
  input  logic                  acc_super,
  output logic [4*NLINES-1:0]   rd_data,
  output logic                  rd_err
);
  localparam int NSLOT = 4;
  localparam int NSRC  = NSLOT * NLINES;

  logic [1:0]      mode_q, slot_q;
  logic [NSRC-1:0] pend;
  logic            chg;

  function automatic logic [NSRC-1:0] range_mask(input logic [1:0] m);
    return {NSRC{1'b1}} >> (NLINES * (3 - int'(m)));
  endfunction

  assign chg  = (mode != mode_q);
  assign slot = slot_q;
  assign line = src[NLINES*slot_q +: NLINES];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= 2'd0;
      slot_q <= 2'd0;
    end else if (chg) begin
      mode_q <= mode;
      slot_q <= 2'd0;
    end else begin
      slot_q <= (slot_q == mode_q) ? 2'd0 : slot_q + 2'd1;
    end

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        pend[k*NLINES +: NLINES] <= '0;
      else if (chg) begin
        if (mode < 2'(k)) pend[k*NLINES +: NLINES] <= '0;
      end else if (slot_q == 2'(k))
        pend[k*NLINES +: NLINES] <= line;

    assert_hold_other_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!chg && slot_q != 2'(k)) |=> $stable(pend[k*NLINES +: NLINES]));
    assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!chg && slot_q == 2'(k)) |=> pend[k*NLINES +: NLINES] == $past(line));
  end

  assign rd_data = (acc_en && !acc_wr && acc_super) ? pend : '0;
  assign rd_err  = acc_en && !acc_super;

  assert_slot_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= mode_q);
  assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg && slot_q == mode_q) |=> slot_q == 2'd0);
  assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg && slot_q != mode_q) |=> slot_q == $past(slot_q) + 2'd1);
  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> (slot_q == 2'd0 && mode_q == $past(mode)));
  assert_out_of_range_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~range_mask(mode_q)) == '0);
  assert_err_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> rd_data == '0);
endmodule

// File: tb/irq_mux_concentrator_test.sv
module irq_mux_concentrator_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 2'd3;
  logic [31:0] src = 32'hFFFF_FFFF;
  logic [7:0] line;
  logic [1:0] slot;
  logic acc_en = 0, acc_wr = 0, acc_super = 0;
  logic [31:0] rd_data;
  logic rd_err;
  int checks = 0, errors = 0;
  bit done = 0;

  irq_mux_concentrator uut (.clk(clk), .rst_n(rst_n), .mode(mode), .src(src),
    .line(line), .slot(slot), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_super(acc_super), .rd_data(rd_data), .rd_err(rd_err));

  always #5 clk = ~clk;

  function automatic logic [31:0] exp_mask(input logic [1:0] m);
    case (m)
      2'd0: return 32'h0000_00FF;
      2'd1: return 32'h0000_FFFF;
      2'd2: return 32'h00FF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sup_read(output logic [31:0] v);
    acc_en = 1; acc_wr = 0; acc_super = 1;
    #1 v = rd_data;
    acc_en = 0; acc_super = 0;
  endtask

  task automatic settle(input logic [1:0] m, input logic [31:0] s);
    @(negedge clk);
    mode = m; src = s;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    @(negedge clk);
    sup_read(v);
    check(v == 0, "R1 pending in reset", v, 0);
    check(slot == 0, "R1 slot in reset", 32'(slot), 0);
    rst_n = 1;
  endtask

  task automatic t_ranges;
    logic [31:0] v;
    logic [31:0] pats [3] = '{32'hA5A5_5A5A, 32'h1234_5678, 32'hDEAD_BEEF};
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 3; p++) begin
        settle(2'(m), pats[p]);
        sup_read(v);
        check(v == (pats[p] & exp_mask(2'(m))), "R5/R7 pending per mode", v, pats[p] & exp_mask(2'(m)));
      end
  endtask

  task automatic t_slots;
    logic [1:0] prev;
    for (int m = 0; m < 4; m++) begin
      settle(2'(m), 32'h8765_4321);
      prev = slot;
      for (int i = 0; i < 9; i++) begin
        @(negedge clk);
        check(slot == ((prev == 2'(m)) ? 2'd0 : prev + 2'd1), "R2 slot sequence",
              32'(slot), 32'((prev == 2'(m)) ? 2'd0 : prev + 2'd1));
        check(line == src[8*slot +: 8], "R3 line content", 32'(line), 32'(src[8*slot +: 8]));
        prev = slot;
      end
    end
  endtask

  task automatic t_hold;
    logic [31:0] v;
    settle(2'd3, 32'h1122_3344);
    while (slot != 2'd0) @(negedge clk);
    src = 32'hAABB_CCDD;
    @(negedge clk);
    sup_read(v);
    check(v == 32'h1122_33DD, "R4 only current slot captured", v, 32'h1122_33DD);
  endtask

  task automatic t_mode_change;
    logic [31:0] v;
    settle(2'd3, 32'hFFFF_FFFF);
    mode = 2'd1; src = 32'h0;
    @(negedge clk);
    sup_read(v);
    check(slot == 0, "R6 slot restart", 32'(slot), 0);
    check(v == 32'h0000_FFFF, "R6 clear and no capture", v, 32'h0000_FFFF);
    @(negedge clk);
    sup_read(v);
    check(v == 32'h0000_FF00, "R6 capture resumes at slot 0", v, 32'h0000_FF00);
    check(slot == 1, "R6 slot after restart", 32'(slot), 1);
  endtask

  task automatic t_access;
    logic [31:0] v;
    settle(2'd3, 32'hC0FF_EE11);
    src = 32'h0;
    mode = 2'd3;
    acc_en = 1; acc_wr = 0; acc_super = 0;
    #1 check(rd_data == 0, "R8 user read data", rd_data, 0);
    check(rd_err == 1, "R8 user read error", 32'(rd_err), 1);
    acc_wr = 1;
    #1 check(rd_err == 1 && rd_data == 0, "R8 user write error", {rd_data[30:0], rd_err}, 1);
    acc_super = 1;
    #1 check(rd_data == 0, "R9 write returns zero", rd_data, 0);
    check(rd_err == 0, "R8 supervisor no error", 32'(rd_err), 0);
    acc_en = 0;
    #1 check(rd_err == 0 && rd_data == 0, "R8 idle port", {rd_data[30:0], rd_err}, 0);
    acc_super = 0; acc_wr = 0;
    src = 32'hC0FF_EE11;
    @(negedge clk);
    acc_en = 1; acc_wr = 1; acc_super = 1;
    @(negedge clk);
    acc_en = 0; acc_wr = 0; acc_super = 0;
    sup_read(v);
    check(v == 32'hC0FF_EE11, "R9 write leaves pending", v, 32'hC0FF_EE11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_ranges();
    t_slots();
    t_hold();
    t_mode_change();
    t_access();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule